// File: doc/BRIEF.md
# ADC Serial Output Engine

This block is the converter side of a three-wire serial link in which the conversion-start line also acts as chip select and the data line also acts as an end-of-conversion interrupt. The host raises the start line while the serial-in pin is held high. The block then runs a conversion, which here is a cycle counter standing in for the analog part. When the counter expires, it captures a 16-bit sample word from a test input. If the start line has behaved as required, the block pulls the data line low so that the host sees an interrupt. It then shifts the word out MSB first, one bit per falling serial-clock edge.

The data line is split into a value and an output enable, so a pad cell outside the block can tri-state the pin. The serial clock and the start line come from the host without any timing relationship to the block. Both are synchronised into the system clock domain, and their edges are detected there.

Top module: `adc_sdo_engine`

## Requirements
- R1: After reset, `sdo_oe` is 0 and `sdo` is 0.
- R2: A rising edge on `cnv` while `sdi` is 1 starts a conversion. When a busy indication follows, `sdo_oe` first reads 1 after exactly CONV_MAX+3 rising `clk` edges, counted from the edge that first samples `cnv` high (two synchroniser stages, one state register, CONV_MAX conversion cycles).
- R3: A rising edge on `cnv` while `sdi` is 0 starts nothing, and `sdo_oe` stays 0.
- R4: During a conversion `sdo_oe` stays 0 whatever `cnv` does. A further rising edge on `cnv` neither restarts nor stretches the conversion.
- R5: The busy indication appears only if the synchronised `cnv` is low on every conversion cycle whose count is CONV_MIN or more. Otherwise `sdo_oe` stays 0 after the conversion ends.
- R6: When the busy indication starts, `sdo` is driven 0 for IRQ_LOW clock cycles, and then carries bit 15 of the captured word.
- R7: Each falling `sck` edge advances `sdo` by one bit, MSB first. After falling edge i (1 to 15), `sdo` shows bit 15-i. After the 16th falling edge it shows 0.
- R8: The 17th falling `sck` edge returns `sdo_oe` to 0.
- R9: If `cnv` goes high during the busy indication or the read-out, `sdo_oe` returns to 0 within four clocks. If `sdi` is 1 at that moment, a new conversion starts at the same time.
- R10: While the data is being read out, `sdo` changes only after a falling `sck` edge. A rising `sck` edge leaves it unchanged.
- R11: The word is captured from `sample_in` when the conversion ends. Changes to `sample_in` after that point do not alter the bits that are shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Conversion start / chip select from the host (asynchronous) |
| sck | input | 1 | Serial clock from the host (asynchronous) |
| sdi | input | 1 | Mode select; must be 1 when `cnv` rises for the link to start |
| sample_in | input | 16 | Test value that stands in for the conversion result |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the data pin; 0 means high impedance |

## Verification
The hardest case to reach is an abort during read-out that starts a new conversion at the same time. It needs a word already partly shifted out, and then a `cnv` rise with `sdi` high that lands in the READ state. The stimulus reads a few bits first and then raises `cnv` at once. It then expects the enable to drop, expects the next interrupt exactly CONV_MAX+3 clocks later, and reads out the new word in full. A second tricky case is a `cnv` pulse during a conversion, before the minimum time. It must neither restart the counter nor suppress the interrupt, and the bench checks this against the exact interrupt cycle.

// File: rtl/adc_sdo_engine.sv
module adc_sdo_engine #(
  parameter int DATA_W   = 16,
  parameter int CONV_MIN = 20,
  parameter int CONV_MAX = 40,
  parameter int IRQ_LOW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CW = $clog2(CONV_MAX + 1);
  localparam int BW = $clog2(DATA_W + 2);
  localparam int IW = $clog2(IRQ_LOW + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CONV = 2'd1, S_IRQ = 2'd2, S_READ = 2'd3} st_t;

  st_t st;
  logic [2:0] cnv_q, sck_q;
  logic [CW-1:0] conv_cnt;
  logic [IW-1:0] irq_cnt;
  logic [BW-1:0] fall_cnt;
  logic [DATA_W-1:0] shreg;
  logic late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= '0;
      sck_q <= '0;
    end else begin
      cnv_q <= {cnv_q[1:0], cnv};
      sck_q <= {sck_q[1:0], sck};
    end
  end

  wire cnv_s    = cnv_q[1];
  wire cnv_rise = cnv_q[1] & ~cnv_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire start    = cnv_rise & sdi;
  wire late_nxt = late | (cnv_s & (conv_cnt >= CW'(CONV_MIN)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      conv_cnt <= '0;
      irq_cnt  <= '0;
      fall_cnt <= '0;
      shreg    <= '0;
      late     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_CONV;
          conv_cnt <= '0;
          late     <= 1'b0;
        end
        S_CONV: begin
          conv_cnt <= conv_cnt + 1'b1;
          late     <= late_nxt;
          if (conv_cnt == CW'(CONV_MAX - 1)) begin
            shreg   <= sample_in;
            irq_cnt <= '0;
            st      <= late_nxt ? S_IDLE : S_IRQ;
          end
        end
        S_IRQ: begin
          if (cnv_s) begin
            st       <= start ? S_CONV : S_IDLE;
            conv_cnt <= '0;
            late     <= 1'b0;
          end else begin
            irq_cnt <= irq_cnt + 1'b1;
            if (irq_cnt == IW'(IRQ_LOW - 1)) begin
              st       <= S_READ;
              fall_cnt <= '0;
            end
          end
        end
        S_READ: begin
          if (cnv_s) begin
            st       <= start ? S_CONV : S_IDLE;
            conv_cnt <= '0;
            late     <= 1'b0;
          end else if (sck_fall) begin
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == BW'(DATA_W)) st <= S_IDLE;
            else shreg <= {shreg[DATA_W-2:0], 1'b0};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sdo_oe = (st == S_IRQ) | (st == S_READ);
  assign sdo    = (st == S_READ) & shreg[DATA_W-1];
endmodule

// File: rtl/adc_sdo_engine_chk.sv
module adc_sdo_engine_chk #(
  parameter int CONV_MAX = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sdi,
  input logic       cnv_s,
  input logic       cnv_rise,
  input logic       sck_fall,
  input logic [1:0] st_code,
  input logic       sdo,
  input logic       sdo_oe
);
  localparam int LW = $clog2(CONV_MAX + 2);
  logic [LW-1:0] conv_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_len <= '0;
    else conv_len <= (st_code == 2'd1) ? conv_len + 1'b1 : '0;
  end

  // R2
  conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(conv_len) == LW'(CONV_MAX - 1));

  // R3
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 2'd0 && cnv_rise && !sdi) |=> st_code == 2'd0);

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  // R9
  cnv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnv_s) && $past(sdo_oe)) |-> !sdo_oe);

  // R10
  stable_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(st_code) == 2'd3 && !$past(sck_fall)) |-> $stable(sdo));
endmodule

bind adc_sdo_engine adc_sdo_engine_chk #(.CONV_MAX(CONV_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdi(sdi), .cnv_s(cnv_s), .cnv_rise(cnv_rise),
  .sck_fall(sck_fall), .st_code(st), .sdo(sdo), .sdo_oe(sdo_oe));

// File: tb/test_adc_sdo_engine.sv
module test_adc_sdo_engine;
  localparam int CMIN = 20;
  localparam int CMAX = 40;
  localparam int IRQL = 2;

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sck = 1'b0, sdi = 1'b1;
  logic [15:0] sample_in = '0;
  logic sdo, sdo_oe;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  adc_sdo_engine #(.DATA_W(16), .CONV_MIN(CMIN), .CONV_MAX(CMAX), .IRQ_LOW(IRQL)) i_adc_sdo_engine (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe));

  // {word, cnv hold cycles, busy indication expected}
  localparam logic [24:0] VEC [5] = '{
    {16'hA5C3, 8'd3,  1'b1},
    {16'h8001, 8'd5,  1'b1},
    {16'h7FFE, 8'd30, 1'b0},
    {16'hFFFF, 8'd2,  1'b1},
    {16'h0000, 8'd70, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic start_conv(input logic [15:0] w, input int hold, input int pon,
                            input int poff, input bit exp_irq);
    bit early = 1'b0;
    sample_in = w;
    sdi = 1'b1;
    cnv = 1'b1;
    for (int k = 1; k <= CMAX + 3; k++) begin
      tick();
      if (k == hold) cnv = 1'b0;
      if (k == pon) cnv = 1'b1;
      if (k == poff) cnv = 1'b0;
      if (k >= 3 && k < CMAX + 3 && sdo_oe) early = 1'b1;
    end
    cnv = 1'b0;
    chk(!early, "R4 oe low during conversion", int'(early), 0);
    chk(sdo_oe == exp_irq, "R2/R5 oe at end of conversion", int'(sdo_oe), int'(exp_irq));
    sample_in = ~w;
    if (!exp_irq) begin
      tick(10);
      chk(!sdo_oe, "R5 no busy indication", int'(sdo_oe), 0);
    end
  endtask

  task automatic read_word(input logic [15:0] w, input int n);
    logic expb;
    chk(sdo == 1'b0, "R6 busy low first cycle", int'(sdo), 0);
    tick();
    chk(sdo == 1'b0, "R6 busy low second cycle", int'(sdo), 0);
    tick();
    chk(sdo == w[15], "R6 D15 after busy low", int'(sdo), int'(w[15]));
    expb = w[15];
    for (int i = 1; i <= n; i++) begin
      sck = 1'b1;
      tick(4);
      chk(sdo == expb, "R10 rising sck no change", int'(sdo), int'(expb));
      sck = 1'b0;
      tick(4);
      if (i <= 15) begin
        expb = w[15-i];
        chk(sdo == expb, "R7 bit after fall", int'(sdo), int'(expb));
        // R11 sample_in already changed; bits still from captured word
      end else if (i == 16) begin
        expb = 1'b0;
        chk(sdo_oe && !sdo, "R7 zero after 16th fall", int'({sdo_oe, sdo}), 2);
      end else begin
        chk(!sdo_oe, "R8 tri-state after 17th fall", int'(sdo_oe), 0);
      end
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(!sdo_oe && !sdo, "R1 reset state", int'({sdo_oe, sdo}), 0);
    rst_n = 1'b1;
    tick(3);
    chk(!sdo_oe && !sdo, "R1 after reset release", int'({sdo_oe, sdo}), 0);

    for (int v = 0; v < 5; v++) begin
      start_conv(VEC[v][24:9], int'(VEC[v][8:1]), 0, 0, VEC[v][0]);
      if (VEC[v][0]) read_word(VEC[v][24:9], 17);
      tick(5);
    end

    // R3: sdi low, no conversion
    sdi = 1'b0;
    cnv = 1'b1;
    tick(CMAX + 10);
    chk(!sdo_oe, "R3 sdi low ignored", int'(sdo_oe), 0);
    cnv = 1'b0;
    sdi = 1'b1;
    tick(5);

    // R4: extra cnv pulse before minimum time does not restart
    start_conv(16'h5A5A, 3, 8, 11, 1'b1);
    read_word(16'h5A5A, 17);
    tick(5);

    // R9: abort with sdi low
    start_conv(16'hC3C3, 3, 0, 0, 1'b1);
    read_word(16'hC3C3, 5);
    sdi = 1'b0;
    cnv = 1'b1;
    tick(4);
    chk(!sdo_oe, "R9 abort tri-state", int'(sdo_oe), 0);
    tick(CMAX + 10);
    chk(!sdo_oe, "R9 abort no new conversion", int'(sdo_oe), 0);
    cnv = 1'b0;
    sdi = 1'b1;
    tick(5);

    // R9: abort with sdi high restarts; R11 new word
    start_conv(16'h1234, 3, 0, 0, 1'b1);
    read_word(16'h1234, 3);
    start_conv(16'hBEEF, 3, 0, 0, 1'b1);
    read_word(16'hBEEF, 17);
    tick(5);

    // R9: abort during busy low phase
    start_conv(16'h00FF, 3, 0, 0, 1'b1);
    sdi = 1'b0;
    cnv = 1'b1;
    tick(4);
    chk(!sdo_oe, "R9 abort during busy low", int'(sdo_oe), 0);
    cnv = 1'b0;
    sdi = 1'b1;
    tick(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule